// File: doc/BRIEF.md
# Countdown Binary-to-Decimal Converter

This block turns an unsigned binary number into packed decimal digits by counting instead of by shift-and-adjust arithmetic. A start strobe captures the binary input in a down-counter and clears a chain of decimal digit counters. On every following clock the down-counter drops by one and the decimal chain rises by one, in the same cycle. When the down-counter reads zero, the decimal chain holds the same quantity. That value is copied into a result register and a done flag is raised.

The logic per cycle is small: a decrementer, a ripple of digit carries and a zero detect. The cost is latency. A conversion of value N takes N+1 clock cycles after the start edge. This suits slow consumers such as a human-readable display fed from a fast datapath. The result register keeps the last finished value while a new conversion runs, so a display reading it never sees a partial count.

Top module: `countdown_bcd_conv`

## Requirements
- R1: After a synchronous reset, `done` is 0 and `bcd_out` is all zeros.
- R2: A clock edge with `start` high captures `bin_in` and clears the decimal digits. `done` is 0 from the next cycle on.
- R3: While a conversion runs, each clock edge lowers the binary working count by exactly one and raises the decimal count by exactly one. For an input value N, `done` first reads 1 exactly N+1 cycles after the start edge.
- R4: On completion, `bcd_out` holds the decimal value of the captured input, four bits per digit. Bits [3:0] hold the ones digit, [7:4] the tens, [11:8] the hundreds, [15:12] the thousands and [19:16] the ten-thousands.
- R5: Every digit stays within 0 to 9. A digit stepping past 9 returns to 0 and advances the next higher digit in the same cycle, so 9, 99 and 9999 roll over into 10, 100 and 10000.
- R6: An input of 0 completes one cycle after the start edge, with no counting cycles and a result of 0.
- R7: Once `done` is 1, it and `bcd_out` stay unchanged until the next start.
- R8: A start arriving during a conversion abandons that conversion and restarts with the new input. Latency and result then follow the new input alone.
- R9: While a conversion runs, `bcd_out` keeps the previous result and does not show the partial count.
- R10: The largest input, 65535, converts correctly after 65536 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a conversion of `bin_in` |
| bin_in | input | 16 | Unsigned binary value to convert, sampled with `start` |
| bcd_out | output | 20 | Last finished result, five packed decimal digits |
| done | output | 1 | High while `bcd_out` holds the result of the latest start |

## Verification
Every result is due at a fixed distance from the start edge: `done` drops one cycle after it and rises N+1 cycles after it, and `bcd_out` changes on that same edge. The bench drives inputs on falling edges and counts falling edges after the start edge until `done` appears. It compares that count with N+1. On each of those falling edges it also confirms that the previous result is still shown. After completion it compares the digits with a decimal split computed in the bench. It then watches further cycles to confirm the output holds.

// File: rtl/cdbcd_pkg.sv
package cdbcd_pkg;

    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] DIGIT_TOP = 4'd9;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } conv_state_e;

endpackage

// File: rtl/cdbcd_digit.sv
module cdbcd_digit
    import cdbcd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               cin,
    output logic [DIGIT_W-1:0] val,
    output logic               cout
);

    typedef struct packed {
        logic [DIGIT_W-1:0] val;
    } digit_regs_t;

    digit_regs_t regs_d, regs_q;

    // carry leaves this digit when it is stepped while at its top value
    assign cout = cin && (regs_q.val == DIGIT_TOP);
    assign val  = regs_q.val;

    always_comb begin
        regs_d = regs_q;
        if (clr) begin
            regs_d.val = '0;
        end else if (cin) begin
            if (regs_q.val == DIGIT_TOP)
                regs_d.val = '0;
            else
                regs_d.val = regs_q.val + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

endmodule

// File: rtl/cdbcd_chain.sv
module cdbcd_chain
    import cdbcd_pkg::*;
#(
    parameter int N_DIGITS = 5,
    localparam int OUT_W = N_DIGITS * DIGIT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [OUT_W-1:0] digits
);

    logic [N_DIGITS:0] carry;

    assign carry[0] = inc;

    for (genvar g = 0; g < N_DIGITS; g++) begin : g_digit
        cdbcd_digit u_digit (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .cin  (carry[g]),
            .val  (digits[g*DIGIT_W +: DIGIT_W]),
            .cout (carry[g+1])
        );
    end

    // carry[N_DIGITS] is the overflow out of the top digit; the width
    // parameters are chosen so that it is never set for a legal input
    logic unused_top_carry;
    assign unused_top_carry = carry[N_DIGITS];

endmodule

// File: rtl/cdbcd_downcnt.sv
module cdbcd_downcnt #(
    parameter int BIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [BIN_W-1:0] load_val,
    input  logic             dec,
    output logic [BIN_W-1:0] cnt,
    output logic             is_zero
);

    typedef struct packed {
        logic [BIN_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t regs_d, regs_q;

    assign cnt     = regs_q.cnt;
    assign is_zero = (regs_q.cnt == '0);

    always_comb begin
        regs_d = regs_q;
        if (load)
            regs_d.cnt = load_val;
        else if (dec && !is_zero)
            regs_d.cnt = regs_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

endmodule

// File: rtl/countdown_bcd_conv.sv
module countdown_bcd_conv
    import cdbcd_pkg::*;
#(
    parameter int BIN_W    = 16,
    parameter int N_DIGITS = 5,
    localparam int OUT_W   = N_DIGITS * DIGIT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BIN_W-1:0] bin_in,
    output logic [OUT_W-1:0] bcd_out,
    output logic             done
);

    typedef struct packed {
        conv_state_e      st;
        logic             done;
        logic [OUT_W-1:0] res;
    } ctrl_regs_t;

    ctrl_regs_t ctrl_d, ctrl_q;

    logic             busy;
    logic             step;
    logic             cnt_zero;
    logic [BIN_W-1:0] cnt_val;
    logic [OUT_W-1:0] digits;

    assign busy = (ctrl_q.st == ST_RUN);
    // one counting step: binary goes down and decimal goes up together
    assign step = busy && !start && !cnt_zero;

    cdbcd_downcnt #(
        .BIN_W (BIN_W)
    ) u_downcnt (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (bin_in),
        .dec      (step),
        .cnt      (cnt_val),
        .is_zero  (cnt_zero)
    );

    cdbcd_chain #(
        .N_DIGITS (N_DIGITS)
    ) u_chain (
        .clk    (clk),
        .rst    (rst),
        .clr    (start),
        .inc    (step),
        .digits (digits)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (start) begin
            ctrl_d.st   = ST_RUN;
            ctrl_d.done = 1'b0;
        end else if (busy && cnt_zero) begin
            ctrl_d.st   = ST_IDLE;
            ctrl_d.done = 1'b1;
            ctrl_d.res  = digits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.st   <= ST_IDLE;
            ctrl_q.done <= 1'b0;
            ctrl_q.res  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign bcd_out = ctrl_q.res;
    assign done    = ctrl_q.done;

endmodule

// File: rtl/cdbcd_chk.sv
module cdbcd_chk #(
    parameter int BIN_W    = 16,
    parameter int N_DIGITS = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic [BIN_W-1:0]      bin_in,
    input logic [N_DIGITS*4-1:0] bcd_out,
    input logic                  done,
    input logic                  busy,
    input logic                  cnt_zero,
    input logic [BIN_W-1:0]      cnt_val,
    input logic [N_DIGITS*4-1:0] digits
);

    // R2
    start_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && !cnt_zero) |=> (cnt_val == $past(cnt_val) - 1'b1));

    // R6
    zero_input_chk: assert property (@(posedge clk) disable iff (rst)
        (start && bin_in == '0) ##1 !start |=> done);

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(bcd_out)));

    // R9
    busy_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && !cnt_zero) |=> $stable(bcd_out));

    for (genvar g = 0; g < N_DIGITS; g++) begin : g_rng
        // R5
        digit_range_chk: assert property (@(posedge clk) disable iff (rst)
            (digits[g*4 +: 4] <= 4'd9) && (bcd_out[g*4 +: 4] <= 4'd9));
    end

endmodule

bind countdown_bcd_conv cdbcd_chk #(
    .BIN_W    (BIN_W),
    .N_DIGITS (N_DIGITS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .bin_in   (bin_in),
    .bcd_out  (bcd_out),
    .done     (done),
    .busy     (busy),
    .cnt_zero (cnt_zero),
    .cnt_val  (cnt_val),
    .digits   (digits)
);

// File: tb/countdown_bcd_conv_test.sv
module countdown_bcd_conv_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] bin_in = '0;
    logic [19:0] bcd_out;
    logic        done;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic [19:0] last_res = '0;

    always #5 clk = ~clk;

    countdown_bcd_conv uut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .bin_in  (bin_in),
        .bcd_out (bcd_out),
        .done    (done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected below 190000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [19:0] dec_split(input int v);
        logic [19:0] r;
        int t;
        t = v;
        for (int i = 0; i < 5; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic ok,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // start a conversion on a falling edge; returns after the start edge
    task automatic pulse_start(input int v);
        @(negedge clk);
        start  = 1'b1;
        bin_in = 16'(v);
        @(negedge clk);
        start  = 1'b0;
    endtask

    // wait for completion, checking latency, frozen output, result
    task automatic finish_conv(input int v, input string req);
        int n;
        logic frozen_ok;
        n = 0;
        frozen_ok = 1'b1;
        check({req, "/R2 done low after start"}, done == 1'b0, done, 0);
        while (!done && n < 70000) begin
            if (bcd_out != last_res) frozen_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        check({req, "/R9 output frozen while counting"}, frozen_ok, frozen_ok, 1);
        check({req, "/R3 latency N+1"}, n == v + 1, n, v + 1);
        check({req, "/R4 decimal result"}, bcd_out == dec_split(v), bcd_out, dec_split(v));
        last_res = bcd_out;
    endtask

    task automatic run_one(input int v, input string req);
        pulse_start(v);
        finish_conv(v, req);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 done after reset", done == 1'b0, done, 0);
        check("R1 bcd_out after reset", bcd_out == '0, bcd_out, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_zero;
        run_one(0, "R6 zero input");
    endtask

    task automatic t_rollovers;
        run_one(9, "R5 nine");
        run_one(10, "R5 ten");
        run_one(99, "R5 ninety-nine");
        run_one(100, "R5 hundred");
        run_one(9999, "R5 9999");
        run_one(10000, "R5 10000");
    endtask

    task automatic t_hold;
        logic ok;
        logic [19:0] snap;
        run_one(4321, "R7 setup");
        snap = bcd_out;
        ok = 1'b1;
        repeat (25) begin
            @(negedge clk);
            if (!done || bcd_out != snap) ok = 1'b0;
        end
        check("R7 done and result held", ok, bcd_out, snap);
    endtask

    task automatic t_restart;
        pulse_start(800);
        repeat (100) @(negedge clk);
        check("R8 still busy before restart", done == 1'b0, done, 0);
        pulse_start(37);
        finish_conv(37, "R8 restart");
    endtask

    task automatic t_random;
        int seed;
        seed = 12345;
        for (int i = 0; i < 8; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            run_one((seed >> 8) % 3000, "R4 random");
        end
    endtask

    task automatic t_max;
        run_one(65535, "R10 max input");
    endtask

    initial begin
        t_reset();
        t_zero();
        t_rollovers();
        t_hold();
        t_restart();
        t_random();
        t_max();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule